// File: doc/BRIEF.md
# CSR Access Legality and Read-Modify-Write Unit

This block sits beside a processor pipeline and judges each control/status register access before it is allowed to touch state. For every request it decodes the 12-bit register number, compares the privilege encoded in that number with the hart's current privilege, and refuses writes to read-only registers. It also applies the gating rules for the user event counters and the floating-point registers. A legal access returns the register's old value and the merged value to be written back. The merged value is (old AND NOT mask) OR (new AND mask). A write strobe is raised only when the mask is nonzero.

The pipeline maps its four instruction forms onto one request shape. A plain read is new=0 with mask=0. A full write is new=value with mask=all ones. A set-bits operation is new=all ones with mask=value. A clear-bits operation is new=0 with mask=value. A small set of registers is held inside the block so that its results can be observed: the FP flags and rounding mode, the machine status word, two scratch registers and the hart identifier. The results are registered and appear in the cycle after the request.

Top module: `csr_access_unit`

## Requirements
- R1: The minimum privilege is register-number bits [9:8], with privileges encoded U=0, S=1, M=3. A request whose privilege is below that value is illegal unless the debugger flag is set.
- R2: A register number with bits [11:10] equal to 3 is read-only. A request to it with a nonzero mask is illegal. The same request with a zero mask is a legal read.
- R3: For a legal request, wdata is (old AND NOT mask) OR (new AND mask). The write strobe is 1 only when the mask is nonzero. All results appear in the cycle after the request, together with rsp_valid.
- R4: For an illegal request, rdata and wdata are 0 and no write strobe is raised. After reset, all outputs are 0 and every internal register reads 0 (except the hart identifier).
- R5: The counter numbers 0xC00 to 0xC1F are illegal when the counter extension is absent. When legal, they read 0.
- R6: With the old spec selected, a counter access below M-mode needs bit (number mod 32) of the machine counter-enable input. In U-mode the same bit of the supervisor counter-enable input is also needed.
- R7: With the newer spec selected, a counter access is legal whenever the counter extension is present, whatever the counter-enable inputs hold.
- R8: The FP registers 0x001, 0x002 and 0x003 are illegal when FP is disabled and the debugger flag is clear. The debugger flag lifts this restriction.
- R9: A legal write to any FP register sets the status FS field (bits [14:13]) to 3. Status bit 31 reads 1 exactly when FS is 3.
- R10: A register number with no implemented register is illegal, and no write strobe is raised for it.
- R11: The supervisor scratch register 0x140 is illegal when supervisor mode is absent.
- R12: The FP flags at 0x001 hold 5 bits and the rounding mode at 0x002 holds 3 bits. 0x003 reads and writes them as {mode[7:5], flags[4:0]}. Status 0x300 stores bits 3, 7, [12:11] and [14:13]. Scratch 0x340 holds all bits. 0x344... is not implemented; 0xF14 reads the HART_ID parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request strobe |
| num_i | input | 12 | Register number |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| dbg_i | input | 1 | Debugger access flag |
| new_i | input | XLEN | New value |
| mask_i | input | XLEN | Write mask |
| spec_old_i | input | 1 | 1 selects the older spec counter rules |
| mcen_i | input | CTR_N | Machine counter-enable bits |
| scen_i | input | CTR_N | Supervisor counter-enable bits |
| fp_en_i | input | 1 | FP unit enabled |
| s_mode_i | input | 1 | Supervisor mode present |
| ctr_ext_i | input | 1 | Counter extension present |
| rsp_valid_o | output | 1 | Results valid for the previous cycle's request |
| illegal_o | output | 1 | Access is illegal |
| rdata_o | output | XLEN | Old register value |
| wdata_o | output | XLEN | Merged write value |
| wstrobe_o | output | 1 | Write performed |

## Verification
Every result (illegal, rdata, wdata, wstrobe and rsp_valid) comes from one register stage. Each is therefore due exactly one clock edge after the edge that samples the request. The internal register set updates on that same edge, so a request in the next cycle already reads the new value. The bench drives each request on a falling edge and holds it through one rising edge. It then samples all outputs at the following falling edge, midway through the cycle in which they are valid. The vector table chains dependent accesses back to back to confirm that each read sees the previous write.

// File: rtl/csr_chk_pkg.sv
package csr_chk_pkg;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam int FS_LO = 13;
  localparam int FS_HI = 14;

  typedef enum logic [3:0] {
    RK_NONE, RK_FFLAGS, RK_FRM, RK_FCSR, RK_CTR,
    RK_STATUS, RK_MSCR, RK_SSCR, RK_HART
  } reg_kind_e;

  function automatic reg_kind_e decode_num(input logic [11:0] n);
    reg_kind_e k;
    case (n)
      12'h001: k = RK_FFLAGS;
      12'h002: k = RK_FRM;
      12'h003: k = RK_FCSR;
      12'h300: k = RK_STATUS;
      12'h340: k = RK_MSCR;
      12'h140: k = RK_SSCR;
      12'hF14: k = RK_HART;
      default: k = (n[11:5] == 7'h60) ? RK_CTR : RK_NONE;
    endcase
    return k;
  endfunction

  function automatic logic is_fp(input reg_kind_e k);
    return (k == RK_FFLAGS) || (k == RK_FRM) || (k == RK_FCSR);
  endfunction

endpackage

// File: rtl/csr_gate.sv
module csr_gate
  import csr_chk_pkg::*;
#(
  parameter int CTR_N = 32,
  localparam int IDX_W = $clog2(CTR_N)
) (
  input  reg_kind_e        kind_i,
  input  logic [1:0]       min_priv_i,
  input  logic             ro_i,
  input  logic [IDX_W-1:0] ctr_idx_i,
  input  logic [1:0]       priv_i,
  input  logic             dbg_i,
  input  logic             mask_nz_i,
  input  logic             spec_old_i,
  input  logic [CTR_N-1:0] mcen_i,
  input  logic [CTR_N-1:0] scen_i,
  input  logic             fp_en_i,
  input  logic             s_mode_i,
  input  logic             ctr_ext_i,
  output logic             illegal_o
);

  logic [CTR_N-1:0] ctr_ok;

  for (genvar i = 0; i < CTR_N; i++) begin : g_ctr_en
    assign ctr_ok[i] = ((priv_i >= PRV_M) || mcen_i[i]) &&
                       ((priv_i >= PRV_S) || scen_i[i]);
  end

  logic priv_fail, ro_fail, ctr_fail, fp_fail, s_fail, none_fail;

  always_comb begin
    priv_fail = !dbg_i && (priv_i < min_priv_i);
    ro_fail   = ro_i && mask_nz_i;
    none_fail = (kind_i == RK_NONE);
    ctr_fail  = 1'b0;
    if (kind_i == RK_CTR) begin
      if (!ctr_ext_i)      ctr_fail = 1'b1;
      else if (spec_old_i) ctr_fail = !ctr_ok[ctr_idx_i];
    end
    fp_fail   = is_fp(kind_i) && !fp_en_i && !dbg_i;
    s_fail    = (kind_i == RK_SSCR) && !s_mode_i;
    illegal_o = priv_fail | ro_fail | none_fail | ctr_fail | fp_fail | s_fail;
  end

endmodule

// File: rtl/csr_state.sv
module csr_state
  import csr_chk_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] HART_ID = 32'd0
) (
  input  logic            clk,
  input  logic            rst,
  input  reg_kind_e       kind_i,
  input  logic            wr_en_i,
  input  logic [XLEN-1:0] wr_data_i,
  output logic [XLEN-1:0] rd_value_o
);

  localparam logic [XLEN-1:0] STATUS_WMASK =
    XLEN'((1 << 3) | (1 << 7) | (3 << 11) | (3 << FS_LO));

  logic [4:0]      fflags_q;
  logic [2:0]      frm_q;
  logic [XLEN-1:0] status_q, mscr_q, sscr_q;
  logic            sd_bit;

  assign sd_bit = (status_q[FS_HI:FS_LO] == 2'b11);

  always_comb begin
    case (kind_i)
      RK_FFLAGS: rd_value_o = XLEN'(fflags_q);
      RK_FRM:    rd_value_o = XLEN'(frm_q);
      RK_FCSR:   rd_value_o = XLEN'({frm_q, fflags_q});
      RK_STATUS: rd_value_o = status_q | {sd_bit, {(XLEN-1){1'b0}}};
      RK_MSCR:   rd_value_o = mscr_q;
      RK_SSCR:   rd_value_o = sscr_q;
      RK_HART:   rd_value_o = XLEN'(HART_ID);
      default:   rd_value_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fflags_q <= '0;
      frm_q    <= '0;
      status_q <= '0;
      mscr_q   <= '0;
      sscr_q   <= '0;
    end else if (wr_en_i) begin
      case (kind_i)
        RK_FFLAGS: fflags_q <= wr_data_i[4:0];
        RK_FRM:    frm_q    <= wr_data_i[2:0];
        RK_FCSR: begin
          frm_q    <= wr_data_i[7:5];
          fflags_q <= wr_data_i[4:0];
        end
        RK_STATUS: status_q <= wr_data_i & STATUS_WMASK;
        RK_MSCR:   mscr_q   <= wr_data_i;
        RK_SSCR:   sscr_q   <= wr_data_i;
        default: ;
      endcase
      if (is_fp(kind_i)) status_q[FS_HI:FS_LO] <= 2'b11;
    end
  end

  // R9
  fs_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && is_fp(kind_i)) |=> (status_q[FS_HI:FS_LO] == 2'b11));

endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csr_chk_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter int          CTR_N   = 32,
  parameter logic [31:0] HART_ID = 32'd0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [11:0]      num_i,
  input  logic [1:0]       priv_i,
  input  logic             dbg_i,
  input  logic [XLEN-1:0]  new_i,
  input  logic [XLEN-1:0]  mask_i,
  input  logic             spec_old_i,
  input  logic [CTR_N-1:0] mcen_i,
  input  logic [CTR_N-1:0] scen_i,
  input  logic             fp_en_i,
  input  logic             s_mode_i,
  input  logic             ctr_ext_i,
  output logic             rsp_valid_o,
  output logic             illegal_o,
  output logic [XLEN-1:0]  rdata_o,
  output logic [XLEN-1:0]  wdata_o,
  output logic             wstrobe_o
);

  localparam int IDX_W = $clog2(CTR_N);

  reg_kind_e       kind;
  logic            ill, mask_nz, do_write;
  logic [XLEN-1:0] old_val, merged;

  assign kind     = decode_num(num_i);
  assign mask_nz  = |mask_i;
  assign merged   = (old_val & ~mask_i) | (new_i & mask_i);
  assign do_write = req_i && !ill && mask_nz;

  csr_gate #(.CTR_N(CTR_N)) u_gate (
    .kind_i     (kind),
    .min_priv_i (num_i[9:8]),
    .ro_i       (num_i[11:10] == 2'b11),
    .ctr_idx_i  (num_i[IDX_W-1:0]),
    .priv_i     (priv_i),
    .dbg_i      (dbg_i),
    .mask_nz_i  (mask_nz),
    .spec_old_i (spec_old_i),
    .mcen_i     (mcen_i),
    .scen_i     (scen_i),
    .fp_en_i    (fp_en_i),
    .s_mode_i   (s_mode_i),
    .ctr_ext_i  (ctr_ext_i),
    .illegal_o  (ill)
  );

  csr_state #(.XLEN(XLEN), .HART_ID(HART_ID)) u_state (
    .clk        (clk),
    .rst        (rst),
    .kind_i     (kind),
    .wr_en_i    (do_write),
    .wr_data_i  (merged),
    .rd_value_o (old_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      illegal_o   <= 1'b0;
      rdata_o     <= '0;
      wdata_o     <= '0;
      wstrobe_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_i;
      illegal_o   <= req_i && ill;
      rdata_o     <= (req_i && !ill) ? old_val : '0;
      wdata_o     <= (req_i && !ill) ? merged : '0;
      wstrobe_o   <= do_write;
    end
  end

  // R1
  low_priv_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && !dbg_i && (priv_i < num_i[9:8])) |=> illegal_o);

  // R2
  ro_write_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && (num_i[11:10] == 2'b11) && (mask_i != '0)) |=> (illegal_o && !wstrobe_o));

  // R3
  pure_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && (mask_i == '0)) |=> !wstrobe_o);

  // R5
  no_ctr_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && (num_i[11:5] == 7'h60) && !ctr_ext_i) |=> illegal_o);

  // R8
  fp_off_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && (num_i == 12'h001) && !fp_en_i && !dbg_i) |=> illegal_o);

endmodule

// File: tb/test_csr_access_unit.sv
`timescale 1ns/1ps
module test_csr_access_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [11:0] num = '0;
  logic [1:0]  priv = 2'd3;
  logic        dbg = 1'b0;
  logic [31:0] nv = '0, mk = '0;
  logic        spec_old = 1'b0;
  logic [31:0] mcen = '1, scen = '1;
  logic        fp_en = 1'b1, s_mode = 1'b1, ctr_ext = 1'b1;
  logic        rsp_valid, illegal, wstrobe;
  logic [31:0] rdata, wdata;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  csr_access_unit #(.XLEN(32), .CTR_N(32), .HART_ID(32'h5)) i_csr_access_unit (
    .clk(clk), .rst(rst), .req_i(req), .num_i(num), .priv_i(priv), .dbg_i(dbg),
    .new_i(nv), .mask_i(mk), .spec_old_i(spec_old), .mcen_i(mcen), .scen_i(scen),
    .fp_en_i(fp_en), .s_mode_i(s_mode), .ctr_ext_i(ctr_ext),
    .rsp_valid_o(rsp_valid), .illegal_o(illegal), .rdata_o(rdata),
    .wdata_o(wdata), .wstrobe_o(wstrobe));

  typedef struct packed {
    logic [11:0] num;
    logic [1:0]  priv;
    logic        dbg;
    logic [31:0] nv;
    logic [31:0] mk;
    logic        ill;
    logic [31:0] rd;
    logic [31:0] wd;
    logic        ws;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{12'h340, 2'd3, 1'b0, 32'hA5A50F0F, 32'hFFFFFFFF, 1'b0, 32'h0,        32'hA5A50F0F, 1'b1, 8'd3},  // R3 write
    '{12'h340, 2'd3, 1'b0, 32'h0,        32'h000000FF, 1'b0, 32'hA5A50F0F, 32'hA5A50F00, 1'b1, 8'd3},  // R3 clear
    '{12'h340, 2'd3, 1'b0, 32'hFFFFFFFF, 32'hF0000000, 1'b0, 32'hA5A50F00, 32'hF5A50F00, 1'b1, 8'd3},  // R3 set
    '{12'h340, 2'd3, 1'b0, 32'h0,        32'h0,        1'b0, 32'hF5A50F00, 32'hF5A50F00, 1'b0, 8'd3},  // R3 read
    '{12'h340, 2'd1, 1'b0, 32'h0,        32'h0,        1'b1, 32'h0,        32'h0,        1'b0, 8'd1},  // R1 low priv
    '{12'h340, 2'd1, 1'b1, 32'h0,        32'h0,        1'b0, 32'hF5A50F00, 32'hF5A50F00, 1'b0, 8'd1},  // R1 debugger
    '{12'hF14, 2'd3, 1'b0, 32'h0,        32'h0,        1'b0, 32'h5,        32'h5,        1'b0, 8'd12}, // R12 hart id
    '{12'hF14, 2'd3, 1'b0, 32'h0,        32'h1,        1'b1, 32'h0,        32'h0,        1'b0, 8'd2},  // R2 ro write
    '{12'h140, 2'd1, 1'b0, 32'h12345678, 32'hFFFFFFFF, 1'b0, 32'h0,        32'h12345678, 1'b1, 8'd11}, // R11 sscratch
    '{12'h140, 2'd0, 1'b0, 32'h0,        32'h0,        1'b1, 32'h0,        32'h0,        1'b0, 8'd1},  // R1 U below S
    '{12'h002, 2'd0, 1'b0, 32'h000000FF, 32'hFFFFFFFF, 1'b0, 32'h0,        32'h000000FF, 1'b1, 8'd12}, // R12 frm
    '{12'h003, 2'd0, 1'b0, 32'h0,        32'h0,        1'b0, 32'h000000E0, 32'h000000E0, 1'b0, 8'd12}, // R12 fcsr
    '{12'h001, 2'd0, 1'b0, 32'h0000001F, 32'h00000003, 1'b0, 32'h0,        32'h00000003, 1'b1, 8'd12}, // R12 fflags
    '{12'h003, 2'd0, 1'b0, 32'h0,        32'h0,        1'b0, 32'h000000E3, 32'h000000E3, 1'b0, 8'd12}, // R12 fcsr
    '{12'h300, 2'd3, 1'b0, 32'h0,        32'h0,        1'b0, 32'h80006000, 32'h80006000, 1'b0, 8'd9},  // R9 dirty
    '{12'h300, 2'd3, 1'b0, 32'h0,        32'h00006000, 1'b0, 32'h80006000, 32'h80000000, 1'b1, 8'd9},  // R9 clear FS
    '{12'h300, 2'd3, 1'b0, 32'h0,        32'h0,        1'b0, 32'h0,        32'h0,        1'b0, 8'd9},  // R9 clean
    '{12'hC00, 2'd0, 1'b0, 32'h0,        32'h0,        1'b0, 32'h0,        32'h0,        1'b0, 8'd7},  // R7 counter
    '{12'hC00, 2'd0, 1'b0, 32'h0,        32'h1,        1'b1, 32'h0,        32'h0,        1'b0, 8'd2},  // R2 counter ro
    '{12'h7C0, 2'd3, 1'b0, 32'h0,        32'h0,        1'b1, 32'h0,        32'h0,        1'b0, 8'd10}, // R10 none
    '{12'h300, 2'd3, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 32'h0,        32'hFFFFFFFF, 1'b1, 8'd12}, // R12 status
    '{12'h300, 2'd3, 1'b0, 32'h0,        32'h0,        1'b0, 32'h80007888, 32'h80007888, 1'b0, 8'd9}   // R9 SD
  };

  task automatic access(input logic [11:0] n, input logic [1:0] p, input logic d,
                        input logic [31:0] v, input logic [31:0] m);
    @(negedge clk);
    num = n; priv = p; dbg = d; nv = v; mk = m; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic check_all(input int tag, input logic e_ill, input logic [31:0] e_rd,
                           input logic [31:0] e_wd, input logic e_ws);
    n_chk++;
    if (rsp_valid !== 1'b1 || illegal !== e_ill || rdata !== e_rd ||
        wdata !== e_wd || wstrobe !== e_ws) begin
      n_bad++;
      $display("FAIL R%0d num=%h: got v=%b ill=%b rd=%h wd=%h ws=%b exp v=1 ill=%b rd=%h wd=%h ws=%b",
               tag, num, rsp_valid, illegal, rdata, wdata, wstrobe, e_ill, e_rd, e_wd, e_ws);
    end
  endtask

  task automatic check_ill(input int tag, input logic e_ill);
    n_chk++;
    if (illegal !== e_ill || (e_ill && wstrobe !== 1'b0)) begin
      n_bad++;
      $display("FAIL R%0d num=%h priv=%0d: got ill=%b ws=%b exp ill=%b", tag, num, priv,
               illegal, wstrobe, e_ill);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung run, exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R4: reset state of outputs
    n_chk++;
    if (rsp_valid !== 0 || illegal !== 0 || wstrobe !== 0 || rdata !== 0 || wdata !== 0) begin
      n_bad++;
      $display("FAIL R4 reset: got v=%b ill=%b ws=%b rd=%h wd=%h exp all 0",
               rsp_valid, illegal, wstrobe, rdata, wdata);
    end

    for (int i = 0; i < NV; i++) begin
      access(TBL[i].num, TBL[i].priv, TBL[i].dbg, TBL[i].nv, TBL[i].mk);
      check_all(int'(TBL[i].tag), TBL[i].ill, TBL[i].rd, TBL[i].wd, TBL[i].ws);
    end

    // R6: old spec counter gating
    spec_old = 1'b1; mcen = 32'h1; scen = 32'h4;
    access(12'hC00, 2'd1, 1'b0, 0, 0); check_ill(6, 1'b0);
    access(12'hC00, 2'd0, 1'b0, 0, 0); check_ill(6, 1'b1);
    access(12'hC02, 2'd1, 1'b0, 0, 0); check_ill(6, 1'b1);
    access(12'hC02, 2'd0, 1'b0, 0, 0); check_ill(6, 1'b1);
    mcen = 32'h5;
    access(12'hC02, 2'd0, 1'b0, 0, 0); check_ill(6, 1'b0);
    mcen = 32'h0; scen = 32'h0;
    access(12'hC00, 2'd3, 1'b0, 0, 0); check_ill(6, 1'b0);
    // R7: newer spec ignores enables
    spec_old = 1'b0;
    access(12'hC1F, 2'd0, 1'b0, 0, 0); check_all(7, 1'b0, 32'h0, 32'h0, 1'b0);
    // R5: extension absent
    ctr_ext = 1'b0;
    access(12'hC00, 2'd3, 1'b0, 0, 0); check_all(5, 1'b1, 32'h0, 32'h0, 1'b0);
    ctr_ext = 1'b1; mcen = '1; scen = '1;
    // R8: FP disabled, debugger bypass
    fp_en = 1'b0;
    access(12'h001, 2'd0, 1'b0, 32'h1F, 32'h1F); check_all(8, 1'b1, 32'h0, 32'h0, 1'b0);
    access(12'h003, 2'd3, 1'b1, 0, 0); check_all(8, 1'b0, 32'hE3, 32'hE3, 1'b0);
    fp_en = 1'b1;
    // R11: supervisor absent
    s_mode = 1'b0;
    access(12'h140, 2'd3, 1'b0, 0, 0); check_all(11, 1'b1, 32'h0, 32'h0, 1'b0);
    s_mode = 1'b1;
    access(12'h140, 2'd3, 1'b0, 0, 0); check_all(11, 1'b0, 32'h12345678, 32'h12345678, 1'b0);
    // R10: unimplemented write suppressed
    access(12'h344, 2'd3, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF); check_all(10, 1'b1, 32'h0, 32'h0, 1'b0);

    // R4: reset clears state
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    access(12'h340, 2'd3, 1'b0, 0, 0); check_all(4, 1'b0, 32'h0, 32'h0, 1'b0);
    access(12'h003, 2'd3, 1'b0, 0, 0); check_all(4, 1'b0, 32'h0, 32'h0, 1'b0);
    access(12'h300, 2'd3, 1'b0, 0, 0); check_all(4, 1'b0, 32'h0, 32'h0, 1'b0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule